// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the bus front end of a byte-wide non-volatile memory and its page buffer. It watches each qualified write strobe, together with its address and data, and decides whether that write may enter the page buffer or must be turned away. It keeps a protect flag that only a dedicated clear input can reset. A separate reset, which models a power transition, leaves the flag as it is.

Protection is switched by timed command sequences of writes, not by a pin. Writing AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h arms protection. The same three writes, placed in front of a page load, also unlock that one load while protection is on. A six-write sequence turns protection off: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 20h to 5555h. Command writes are consumed and never stored. The block also owns the byte-load window and the programming-period timer. A flag change takes effect only when the programming period that follows the command ends. A write that protection turns away still runs a full busy period, so from outside it looks like a real write cycle.

Every write belongs to one of three kinds: a command step, an ordinary write, or a write into an open page load. Command matching runs only while no page load is open.

Top module: `swp_seq`

## Requirements
- R1: After `nv_clr_n` and `rst_n` are released, `prot_on` is 0, `busy` is 0, and `wr_pass` and `dummy_start` are 0 while no strobe is present.
- R2: With protection off, an ordinary write raises `wr_pass` in the cycle of its strobe and opens a page load. Further writes pass while each one comes within WIN_CYC cycles of the previous one. WIN_CYC cycles after the last write of the load, `busy` rises and stays high for exactly TWC_CYC cycles.
- R3: The arming sequence (AAh to 5555h, 55h to 2AAAh, A0h to 5555h, each within the load window) passes none of its writes. `prot_on` becomes 1 exactly when the busy period that follows ends, and not one cycle earlier.
- R4: While protected, a write that is not preceded by a command does not pass. It raises `dummy_start` for one cycle, and `busy` is high for exactly TWC_CYC cycles starting on the next edge. `prot_on` is unchanged afterwards.
- R5: While protected, writes that follow a completed arming sequence within the window pass and form one page load. After that load, protection stays on, and the next bare write is blocked again.
- R6: The six-write disarm sequence passes none of its writes and unlocks a following page load. `prot_on` becomes 0 exactly when the busy period that follows ends.
- R7: A command write that comes exactly WIN_CYC cycles after the previous command write is still accepted. At WIN_CYC+1 cycles the partial sequence has already been abandoned, with no busy period, and the late write is handled as an ordinary write.
- R8: A write that does not match the next expected command step returns the matcher to idle. That write is handled as an ordinary write: it passes when protection is off and raises `dummy_start` when protection is on. The matched prefix writes are discarded.
- R9: While `busy` is high, strobes are ignored. Neither `wr_pass` nor `dummy_start` rises, and the command matcher does not advance.
- R10: Asserting `rst_n` leaves `prot_on` unchanged. Asserting `nv_clr_n` clears it at once.
- R11: `wr_pass` and `dummy_start` are never high in the same cycle.
- R12: While a page load is open, writes that look like command steps are stored as ordinary page data and arm nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low sequencer reset (a power transition); keeps the flag |
| nv_clr_n | input | 1 | Active-low clear of the non-volatile protect flag |
| wr_strobe | input | 1 | One-cycle qualified write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_pass | output | 1 | This write goes to the page buffer |
| dummy_start | output | 1 | A blocked write starts a data-less programming cycle |
| busy | output | 1 | Programming period in progress |
| prot_on | output | 1 | Protect flag |

## Verification
The byte-load window can run out in the same cycle that the next write strobe arrives. The block must let the strobe win, so that the write is accepted and the sequence or page load goes on. The bench provokes this by placing the third command write at gaps of WIN_CYC-1, WIN_CYC and WIN_CYC+1 cycles after the second. It judges the outcome from `dummy_start`, `busy` and whether the following data write passes. A second collision is a strobe that lands while the programming timer runs. The bench sends a command prefix during `busy` and confirms that the remaining command steps are later handled as plain writes.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_LOAD = 2'd2,
    ST_BUSY = 2'd3
  } swp_state_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SET  = 2'd1,
    PEND_CLR  = 2'd2
  } swp_pend_e;

  localparam int unsigned STEP_ARM  = 2;
  localparam int unsigned STEP_LAST = 5;
  localparam logic [7:0]  ARM_BYTE  = 8'hA0;

  // expected data byte of a command step on the disarm path
  function automatic logic [7:0] step_byte(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: step_byte = 8'hAA;
      3'd1, 3'd4: step_byte = 8'h55;
      3'd2:       step_byte = 8'h80;
      3'd5:       step_byte = 8'h20;
      default:    step_byte = 8'h00;
    endcase
  endfunction

  // steps that target the second command address
  function automatic logic step_on_b(input logic [2:0] step);
    step_on_b = (step == 3'd1) || (step == 3'd4);
  endfunction

  // last counter value of a window of lim cycles
  function automatic logic win_end(input int unsigned cnt, input int unsigned lim);
    win_end = (cnt + 1 == lim);
  endfunction

endpackage

// File: rtl/swp_cmd_match.sv
module swp_cmd_match
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA
) (
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic              fin_set_o,
  output logic              fin_clr_o
);

  logic [ADDR_W-1:0] exp_addr;
  logic              addr_ok;
  logic              seq_ok;

  always_comb begin
    exp_addr  = step_on_b(step_i) ? ADDR_B : ADDR_A;
    addr_ok   = (addr_i == exp_addr);
    seq_ok    = addr_ok && (data_i == DATA_W'(step_byte(step_i)));
    fin_set_o = addr_ok && (32'(step_i) == STEP_ARM) && (data_i == DATA_W'(ARM_BYTE));
    fin_clr_o = seq_ok && (32'(step_i) == STEP_LAST);
    hit_o     = seq_ok || fin_set_o;
  end

  always_comb begin
    AST_FINISH_EXCL: assert (!(fin_set_o && fin_clr_o)); // R8
  end

endmodule

// File: rtl/swp_timer.sv
module swp_timer
  import swp_pkg::*;
#(
  parameter int unsigned WIN_CYC = 16,
  parameter int unsigned TWC_CYC = 40,
  localparam int unsigned CNT_MAX = (WIN_CYC > TWC_CYC) ? WIN_CYC : TWC_CYC,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic in_busy_i,
  output logic expire_o
);

  logic [CNT_W-1:0] cnt_q;
  int unsigned      lim;

  always_comb begin
    lim      = in_busy_i ? TWC_CYC : WIN_CYC;
    expire_o = win_end(32'(cnt_q), lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (!expire_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < CNT_MAX); // R2

endmodule

// File: rtl/swp_flag.sv
module swp_flag
  import swp_pkg::*;
(
  input  logic      clk,
  input  logic      nv_clr_n,
  input  logic      commit_i,
  input  swp_pend_e pend_i,
  output logic      prot_o
);

  logic prot_q;

  always_ff @(posedge clk or negedge nv_clr_n) begin
    if (!nv_clr_n) prot_q <= 1'b0;
    else if (commit_i) begin
      if (pend_i == PEND_SET)      prot_q <= 1'b1;
      else if (pend_i == PEND_CLR) prot_q <= 1'b0;
    end
  end

  assign prot_o = prot_q;

endmodule

// File: rtl/swp_seq.sv
module swp_seq
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WIN_CYC = 16,
  parameter int unsigned TWC_CYC = 40,
  parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_clr_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_pass,
  output logic              dummy_start,
  output logic              busy,
  output logic              prot_on
);

  swp_state_e state_q, state_d;
  swp_pend_e  pend_q, pend_d;
  logic [2:0] step_q, step_d;
  logic [2:0] step_cur;

  logic hit, fin_set, fin_clr;
  logic can_cmd, cmd_hit, plain_wr, load_wr, accepted;
  logic expire, restart, commit;

  // matcher sees step 0 whenever no command is in progress
  assign step_cur = (state_q == ST_CMD) ? step_q : 3'd0;

  swp_cmd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_match (
    .step_i(step_cur), .addr_i(wr_addr), .data_i(wr_data),
    .hit_o(hit), .fin_set_o(fin_set), .fin_clr_o(fin_clr)
  );

  // write classification
  always_comb begin
    can_cmd     = (state_q == ST_IDLE) || (state_q == ST_CMD);
    cmd_hit     = wr_strobe && can_cmd && hit;
    plain_wr    = wr_strobe && can_cmd && !hit;
    load_wr     = wr_strobe && (state_q == ST_LOAD);
    accepted    = cmd_hit || plain_wr || load_wr;
    wr_pass     = load_wr || (plain_wr && !prot_on);
    dummy_start = plain_wr && prot_on;
    busy        = (state_q == ST_BUSY);
  end

  // sequencing
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        pend_d = PEND_NONE;
        if (cmd_hit) begin
          state_d = ST_CMD;
          step_d  = 3'd1;
        end else if (plain_wr) begin
          state_d = prot_on ? ST_BUSY : ST_LOAD;
        end
      end
      ST_CMD: begin
        if (cmd_hit) begin
          if (fin_set) begin
            state_d = ST_LOAD;
            pend_d  = PEND_SET;
          end else if (fin_clr) begin
            state_d = ST_LOAD;
            pend_d  = PEND_CLR;
          end else begin
            step_d = step_q + 3'd1;
          end
        end else if (plain_wr) begin
          state_d = prot_on ? ST_BUSY : ST_LOAD;
          pend_d  = PEND_NONE;
        end else if (expire) begin
          state_d = ST_IDLE;
        end
      end
      ST_LOAD: begin
        if (!wr_strobe && expire) state_d = ST_BUSY;
      end
      ST_BUSY: begin
        if (expire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign restart = accepted || (state_d != state_q);
  assign commit  = (state_q == ST_BUSY) && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= 3'd0;
      pend_q  <= PEND_NONE;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      pend_q  <= pend_d;
    end
  end

  swp_timer #(.WIN_CYC(WIN_CYC), .TWC_CYC(TWC_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .in_busy_i(busy), .expire_o(expire)
  );

  swp_flag u_flag (
    .clk(clk), .nv_clr_n(nv_clr_n), .commit_i(commit),
    .pend_i(pend_q), .prot_o(prot_on)
  );

  AST_PASS_DUMMY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pass && dummy_start)); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_pass && !dummy_start)); // R9
  AST_DUMMY_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_start |=> busy); // R4
  AST_CMD_NOT_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> !wr_pass); // R3
  AST_PROT_BARE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && prot_on && wr_strobe && !hit) |-> !wr_pass); // R4
  AST_FLAG_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
    !$stable(prot_on) |-> ($past(busy) && !busy)); // R3
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD) |-> (step_q >= 3'd1 && step_q <= 3'd5)); // R6

endmodule

// File: tb/swp_seq_test.sv
module swp_seq_test;

  localparam int CLK_P = 10;
  localparam int WIN   = 6;
  localparam int TWC   = 10;
  localparam logic [14:0] A = 15'h5555;
  localparam logic [14:0] B = 15'h2AAA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nv_clr_n = 1'b0;
  logic wr_strobe = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_pass, dummy_start, busy, prot_on;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  swp_seq #(.ADDR_W(15), .DATA_W(8), .WIN_CYC(WIN), .TWC_CYC(TWC)) uut (
    .clk(clk), .rst_n(rst_n), .nv_clr_n(nv_clr_n), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_pass(wr_pass),
    .dummy_start(dummy_start), .busy(busy), .prot_on(prot_on)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic put(input string req, input logic [14:0] a, input logic [7:0] d,
                     input int exp_p, input int exp_q);
    int p, q;
    @(negedge clk);
    wr_strobe = 1'b1;
    wr_addr = a;
    wr_data = d;
    #1;
    p = int'(wr_pass);
    q = int'(dummy_start);
    chk("R11", "pass and dummy together", int'(p != 0 && q != 0), 0);
    chk(req, "wr_pass", p, exp_p);
    chk(req, "dummy_start", q, exp_q);
    @(posedge clk);
    #1 wr_strobe = 1'b0;
  endtask

  function automatic logic [14:0] dis_addr(input int i);
    return (i == 1 || i == 4) ? B : A;
  endfunction

  function automatic logic [7:0] dis_data(input int i);
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2:    return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic arm_seq(input string req);
    put(req, A, 8'hAA, 0, 0);
    put(req, B, 8'h55, 0, 0);
    put(req, A, 8'hA0, 0, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk);
    nv_clr_n = 1'b1;
    rst_n = 1'b1;
    edges(2);
    // R1 reset state
    chk("R1", "prot_on", int'(prot_on), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "wr_pass idle", int'(wr_pass), 0);
    chk("R1", "dummy idle", int'(dummy_start), 0);

    // R2 single write, busy timing
    put("R2", 15'h0123, 8'h11, 1, 0);
    edges(WIN - 1);
    chk("R2", "busy before window end", int'(busy), 0);
    edges(1);
    chk("R2", "busy at window end", int'(busy), 1);
    edges(TWC - 1);
    chk("R2", "busy last cycle", int'(busy), 1);
    edges(1);
    chk("R2", "busy after tWC", int'(busy), 0);

    // R2 page load with every gap up to the window
    for (int g = 1; g <= WIN; g++) begin
      if (g > 1) edges(g - 1);
      put("R2", 15'(15'h0040 + g), 8'(g), 1, 0);
    end
    edges(WIN + TWC + 2);

    // R9 strobes during busy are ignored, matcher not advanced
    put("R9", 15'h0200, 8'h01, 1, 0);
    edges(WIN);
    chk("R9", "busy", int'(busy), 1);
    put("R9", A, 8'hAA, 0, 0);
    edges(TWC + 1);
    put("R9", B, 8'h55, 1, 0);
    edges(WIN + TWC + 2);
    chk("R9", "prot_on", int'(prot_on), 0);

    // R3 arm
    arm_seq("R3");
    edges(WIN + TWC - 1);
    chk("R3", "prot_on before busy end", int'(prot_on), 0);
    chk("R3", "busy last cycle", int'(busy), 1);
    edges(1);
    chk("R3", "prot_on after busy end", int'(prot_on), 1);

    // R4 bare write while protected
    put("R4", 15'h0200, 8'h77, 0, 1);
    chk("R4", "busy after dummy", int'(busy), 1);
    edges(TWC - 1);
    chk("R4", "busy last cycle", int'(busy), 1);
    edges(1);
    chk("R4", "busy ended", int'(busy), 0);
    chk("R4", "prot_on kept", int'(prot_on), 1);

    // R10 sequencer reset keeps flag
    @(negedge clk) rst_n = 1'b0;
    edges(2);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    chk("R10", "prot_on after rst_n", int'(prot_on), 1);
    chk("R10", "busy after rst_n", int'(busy), 0);

    // R5 unlocked page write while protected
    arm_seq("R5");
    put("R5", 15'h0300, 8'h12, 1, 0);
    edges(2);
    put("R5", 15'h0301, 8'h34, 1, 0);
    edges(WIN + TWC + 2);
    chk("R5", "prot_on kept", int'(prot_on), 1);
    put("R5", 15'h0302, 8'h56, 0, 1);
    edges(TWC + 2);

    // R7 window boundary on the third command write
    for (int g = WIN - 1; g <= WIN + 1; g++) begin
      put("R7", A, 8'hAA, 0, 0);
      put("R7", B, 8'h55, 0, 0);
      edges(g - 1);
      if (g <= WIN) begin
        put("R7", A, 8'hA0, 0, 0);
        put("R7", 15'h0500, 8'h9C, 1, 0);
        edges(WIN + TWC + 2);
      end else begin
        chk("R7", "busy after abandon", int'(busy), 0);
        put("R7", A, 8'hA0, 0, 1);
        edges(TWC + 2);
      end
    end
    chk("R7", "prot_on", int'(prot_on), 1);

    // R8 break at each position of the disarm sequence, protected
    for (int k = 0; k <= 5; k++) begin
      for (int i = 0; i < k; i++) put("R8", dis_addr(i), dis_data(i), 0, 0);
      put("R8", 15'h0100, 8'h33, 0, 1);
      edges(TWC + 2);
      chk("R8", "prot_on after break", int'(prot_on), 1);
    end

    // R6 disarm
    for (int i = 0; i <= 5; i++) put("R6", dis_addr(i), dis_data(i), 0, 0);
    put("R6", 15'h0600, 8'h42, 1, 0);
    edges(WIN + TWC - 1);
    chk("R6", "prot_on before busy end", int'(prot_on), 1);
    edges(1);
    chk("R6", "prot_on after busy end", int'(prot_on), 0);

    // R12 command-like writes inside an open load
    put("R12", 15'h0400, 8'h01, 1, 0);
    put("R12", A, 8'hAA, 1, 0);
    put("R12", B, 8'h55, 1, 0);
    put("R12", A, 8'hA0, 1, 0);
    edges(WIN + TWC + 2);
    chk("R12", "prot_on", int'(prot_on), 0);

    // R8 break while unprotected
    put("R8", A, 8'hAA, 0, 0);
    put("R8", 15'h0100, 8'h33, 1, 0);
    edges(WIN + TWC + 2);
    chk("R8", "prot_on unprotected break", int'(prot_on), 0);

    // R10 flag clear input
    arm_seq("R10");
    edges(WIN + TWC + 2);
    chk("R10", "prot_on armed", int'(prot_on), 1);
    @(negedge clk) nv_clr_n = 1'b0;
    #1;
    chk("R10", "prot_on during clear", int'(prot_on), 0);
    @(negedge clk) nv_clr_n = 1'b1;
    edges(1);
    chk("R10", "prot_on after clear", int'(prot_on), 0);

    summary();
    $finish;
  end

endmodule